// File: doc/BRIEF.md
# Coprocessor Run, Cache-Base and Loop Control

This block carries out three control instructions of a small 16-bit graphics coprocessor core. The halt instruction drops the core's running flag and may raise an interrupt request toward the host. The cache-setup instruction computes a new instruction-cache base from the program counter and tells the instruction cache to flush. The counted-loop instruction decrements the loop counter register, updates the sign and zero flags and, unless the counter reached zero, redirects the program counter.

The decoder presents one instruction per cycle as a valid strobe plus a 2-bit class. The block answers the loop instruction in the same cycle, through a counter write port, a flag write port and a next-PC select with its target address. Running, interrupt request, cache base and cache-active state are registered. The cache memory, the ALU and instruction fetch are outside this block.

Top module: `cop_flow_ctl`

## Requirements
- R1: On a valid halt (class 2'b01), `running` is 0 after the next clock edge. `go_set` without a halt in the same cycle sets `running` at the next edge. When both come together, the halt wins.
- R2: A valid halt sets `irq` at the next edge when configuration bit 7 is 0. When that bit is 1, the halt leaves `irq` unchanged.
- R3: `irq` stays high until a cycle with `irq_ack` high clears it at the next edge. If an unmasked halt arrives in the same cycle as `irq_ack`, `irq` stays set.
- R4: A valid cache-setup (class 2'b10) computes the new base as the low 16 bits of (`pc` − `bank_base`) ANDed with 16'hFFF0. It loads that base into `cache_base` and sets `cache_active` at the next edge.
- R5: A base load makes `cache_flush` high for exactly the one cycle after the cache-setup edge.
- R6: A cache-setup has no effect on `cache_base`, `cache_active` or `cache_flush` when `cache_active` is already 1, or when the new base equals the current base.
- R7: A valid loop (class 2'b11) asserts `cnt_wr_en` and `flag_wr_en` in the same cycle. It drives `cnt_wr_data` = `loop_cnt` − 1 (mod 2^16), `flag_sign` = bit 15 of that value and `flag_zero` = (that value == 0).
- R8: A valid loop asserts `pc_jump` with `pc_jump_addr` = `bank_base` + zero-extended `loop_tgt` when the decremented counter is nonzero. When it is zero, `pc_jump` stays 0. Outside a valid loop, `pc_jump`, `cnt_wr_en` and `flag_wr_en` are 0.
- R9: `prefix_clear` is 1 in the same cycle as any valid halt, cache-setup or loop, and 0 for class 2'b00 or when `instr_valid` is low.
- R10: While `rst_n` is low at a clock edge, `running`, `irq`, `cache_active`, `cache_flush` and `cache_base` are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| instr_valid | input | 1 | Decoded instruction strobe |
| op_kind | input | 2 | Class: 00 other, 01 halt, 10 cache-setup, 11 loop |
| pc | input | 24 | Current program counter (absolute) |
| bank_base | input | 24 | Program bank base address |
| cfg_reg | input | 8 | Configuration register; bit 7 masks the interrupt |
| go_set | input | 1 | Start request that sets the running flag |
| irq_ack | input | 1 | Host acknowledge that clears `irq` |
| loop_cnt | input | 16 | Loop counter register value |
| loop_tgt | input | 16 | Loop target register value |
| running | output | 1 | Running flag of the status register |
| irq | output | 1 | Interrupt request |
| cache_base | output | 16 | Cache base offset |
| cache_active | output | 1 | Cache holds a loaded base |
| cache_flush | output | 1 | One-cycle flush pulse to the instruction cache |
| cnt_wr_en | output | 1 | Loop counter write enable |
| cnt_wr_data | output | 16 | Decremented loop counter |
| flag_wr_en | output | 1 | Sign/zero flag write enable |
| flag_sign | output | 1 | New sign flag |
| flag_zero | output | 1 | New zero flag |
| pc_jump | output | 1 | Next-PC select: take `pc_jump_addr` |
| pc_jump_addr | output | 24 | Loop branch target |
| prefix_clear | output | 1 | Clear pending prefix state |

## Verification
The assertions assume that `op_kind` is meaningful only while `instr_valid` is high. They assume `irq_ack` and `go_set` are single-cycle levels that the host may drive at any time, including in the same cycle as a halt. They also assume that `loop_cnt` and `loop_tgt` are stable during the loop cycle. The stimulus draws every input from a seeded `$urandom` stream, so acknowledges, starts and halts collide freely. Repeated resets return the cache-active state to zero, which lets cache-setup loads recur. Directed cases cover the equal-base suppression right after reset, a masked halt, an acknowledge in the same cycle as a halt, and loop counters of 1 and 0.

// File: rtl/cop_flow_pkg.sv
// Shared types of the run/cache/loop control block.
// Assumes: the decoder supplies a 2-bit instruction class.
package cop_flow_pkg;
    typedef enum logic [1:0] {
        OP_OTHER = 2'b00,
        OP_STOP  = 2'b01,
        OP_CACHE = 2'b10,
        OP_LOOP  = 2'b11
    } op_kind_e;
endpackage

// File: rtl/cop_run_ctl.sv
// Running flag and interrupt request.
// Assumes: stop_req is a single-cycle decoded halt; irq_ack comes from the host.
module cop_run_ctl #(
    parameter int CFG_W        = 8,
    parameter int IRQ_MASK_BIT = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stop_req,
    input  logic             go_set,
    input  logic             irq_ack,
    input  logic [CFG_W-1:0] cfg,
    output logic             running,
    output logic             irq
);
    logic irq_unmasked;
    assign irq_unmasked = ~cfg[IRQ_MASK_BIT];

    // Running flag: halt has priority over start.
    always_ff @(posedge clk) begin
        if (!rst_n)        running <= 1'b0;
        else if (stop_req) running <= 1'b0;
        else if (go_set)   running <= 1'b1;
    end

    // Interrupt request: an unmasked halt sets it, acknowledge clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)                        irq <= 1'b0;
        else if (stop_req && irq_unmasked) irq <= 1'b1;
        else if (irq_ack)                  irq <= 1'b0;
    end

    AST_STOP_CLEARS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        stop_req |=> !running); // R1
    AST_GO_SETS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (go_set && !stop_req) |=> running); // R1
    AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_req && !cfg[IRQ_MASK_BIT]) |=> irq); // R2
    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_req && cfg[IRQ_MASK_BIT] && !irq) |=> !irq); // R2
    AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !irq_ack) |=> irq); // R3
endmodule

// File: rtl/cop_cache_ctl.sv
// Cache base register, cache-active indicator and flush strobe.
// Assumes: a loaded base stays in use until reset; the flush is registered.
module cop_cache_ctl #(
    parameter int ADDR_W     = 24,
    parameter int BASE_W     = 16,
    parameter int LINE_BYTES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cache_req,
    input  logic [ADDR_W-1:0] pc,
    input  logic [ADDR_W-1:0] bank_base,
    output logic [BASE_W-1:0] cache_base,
    output logic              cache_active,
    output logic              cache_flush
);
    localparam int OFS_W = $clog2(LINE_BYTES);

    logic [ADDR_W-1:0] pc_offset;
    logic [BASE_W-1:0] new_base;
    logic              do_load;

    // Offset in the bank, aligned down to a cache line.
    always_comb begin
        pc_offset = pc - bank_base;
        new_base  = {pc_offset[BASE_W-1:OFS_W], {OFS_W{1'b0}}};
        do_load   = cache_req && !cache_active && (new_base != cache_base);
    end

    // Base register and active indicator.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cache_base   <= '0;
            cache_active <= 1'b0;
        end else if (do_load) begin
            cache_base   <= new_base;
            cache_active <= 1'b1;
        end
    end

    // One-cycle flush after each load.
    always_ff @(posedge clk) begin
        if (!rst_n) cache_flush <= 1'b0;
        else        cache_flush <= do_load;
    end

    AST_FLUSH_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        cache_flush |=> !cache_flush); // R5
    AST_FLUSH_WITH_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        cache_flush |-> cache_active); // R4
    AST_ACTIVE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        cache_active |=> (cache_active && $stable(cache_base))); // R6
    AST_BASE_SAME_NO_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        (cache_req && (new_base == cache_base)) |=> !cache_flush); // R6
endmodule

// File: rtl/cop_loop_unit.sv
// Counted-loop execution: decrement, flags, branch select.
// Assumes: loop_cnt/loop_tgt are the current register values; purely combinational.
module cop_loop_unit #(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 16
) (
    input  logic              loop_req,
    input  logic [DATA_W-1:0] loop_cnt,
    input  logic [DATA_W-1:0] loop_tgt,
    input  logic [ADDR_W-1:0] bank_base,
    output logic              cnt_wr_en,
    output logic [DATA_W-1:0] cnt_wr_data,
    output logic              flag_wr_en,
    output logic              flag_sign,
    output logic              flag_zero,
    output logic              pc_jump,
    output logic [ADDR_W-1:0] pc_jump_addr
);
    logic [DATA_W-1:0] dec_val;

    // Decrement and derive the flags and the branch decision.
    always_comb begin
        dec_val      = loop_cnt - DATA_W'(1);
        cnt_wr_en    = loop_req;
        cnt_wr_data  = dec_val;
        flag_wr_en   = loop_req;
        flag_sign    = dec_val[DATA_W-1];
        flag_zero    = (dec_val == '0);
        pc_jump      = loop_req && (dec_val != '0);
        pc_jump_addr = bank_base + ADDR_W'(loop_tgt);
    end

    always_comb begin
        AST_LOOP_EXIT: assert (!(loop_req && loop_cnt == DATA_W'(1)) || !pc_jump); // R8
        AST_LOOP_TAKEN: assert (!(loop_req && loop_cnt != DATA_W'(1)) || pc_jump); // R8
        AST_IDLE_NO_WRITE: assert (loop_req || (!cnt_wr_en && !flag_wr_en && !pc_jump)); // R7
    end
endmodule

// File: rtl/cop_flow_ctl.sv
// Top: decodes the instruction class and routes it to the halt, cache-setup
// and loop handlers; clears prefix state after any of them.
// Assumes: one decoded instruction per cycle, synchronous active-low reset.
module cop_flow_ctl
    import cop_flow_pkg::*;
#(
    parameter int ADDR_W       = 24,
    parameter int DATA_W       = 16,
    parameter int CFG_W        = 8,
    parameter int IRQ_MASK_BIT = 7,
    parameter int LINE_BYTES   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              instr_valid,
    input  logic [1:0]        op_kind,
    input  logic [ADDR_W-1:0] pc,
    input  logic [ADDR_W-1:0] bank_base,
    input  logic [CFG_W-1:0]  cfg_reg,
    input  logic              go_set,
    input  logic              irq_ack,
    input  logic [DATA_W-1:0] loop_cnt,
    input  logic [DATA_W-1:0] loop_tgt,
    output logic              running,
    output logic              irq,
    output logic [DATA_W-1:0] cache_base,
    output logic              cache_active,
    output logic              cache_flush,
    output logic              cnt_wr_en,
    output logic [DATA_W-1:0] cnt_wr_data,
    output logic              flag_wr_en,
    output logic              flag_sign,
    output logic              flag_zero,
    output logic              pc_jump,
    output logic [ADDR_W-1:0] pc_jump_addr,
    output logic              prefix_clear
);
    op_kind_e kind;
    logic     stop_req, cache_req, loop_req;

    // Class decode gated by the strobe.
    always_comb begin
        kind         = op_kind_e'(op_kind);
        stop_req     = instr_valid && (kind == OP_STOP);
        cache_req    = instr_valid && (kind == OP_CACHE);
        loop_req     = instr_valid && (kind == OP_LOOP);
        prefix_clear = stop_req || cache_req || loop_req;
    end

    cop_run_ctl #(.CFG_W(CFG_W), .IRQ_MASK_BIT(IRQ_MASK_BIT)) u_run (
        .clk(clk), .rst_n(rst_n), .stop_req(stop_req), .go_set(go_set),
        .irq_ack(irq_ack), .cfg(cfg_reg), .running(running), .irq(irq)
    );

    cop_cache_ctl #(.ADDR_W(ADDR_W), .BASE_W(DATA_W), .LINE_BYTES(LINE_BYTES)) u_cache (
        .clk(clk), .rst_n(rst_n), .cache_req(cache_req), .pc(pc),
        .bank_base(bank_base), .cache_base(cache_base),
        .cache_active(cache_active), .cache_flush(cache_flush)
    );

    cop_loop_unit #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_loop (
        .loop_req(loop_req), .loop_cnt(loop_cnt), .loop_tgt(loop_tgt),
        .bank_base(bank_base), .cnt_wr_en(cnt_wr_en), .cnt_wr_data(cnt_wr_data),
        .flag_wr_en(flag_wr_en), .flag_sign(flag_sign), .flag_zero(flag_zero),
        .pc_jump(pc_jump), .pc_jump_addr(pc_jump_addr)
    );

    always_comb begin
        AST_PREFIX_IDLE: assert (instr_valid || !prefix_clear); // R9
    end
    AST_RESET_STATE: assert property (@(posedge clk)
        !rst_n |=> (!running && !irq && !cache_active && !cache_flush)); // R10
endmodule

// File: tb/cop_flow_ctl_bench.sv
module cop_flow_ctl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_valid = 1'b0;
    logic [1:0]  op_kind = 2'b00;
    logic [23:0] pc = '0, bank_base = '0;
    logic [7:0]  cfg_reg = '0;
    logic        go_set = 1'b0, irq_ack = 1'b0;
    logic [15:0] loop_cnt = '0, loop_tgt = '0;
    logic        running, irq, cache_active, cache_flush;
    logic [15:0] cache_base, cnt_wr_data;
    logic        cnt_wr_en, flag_wr_en, flag_sign, flag_zero, pc_jump, prefix_clear;
    logic [23:0] pc_jump_addr;

    int total = 0, fails = 0;
    bit done = 0;
    logic        m_run, m_irq, m_act, m_flush;
    logic [15:0] m_base;

    always #4 clk = ~clk;

    cop_flow_ctl u_cop_flow_ctl (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .op_kind(op_kind),
        .pc(pc), .bank_base(bank_base), .cfg_reg(cfg_reg), .go_set(go_set),
        .irq_ack(irq_ack), .loop_cnt(loop_cnt), .loop_tgt(loop_tgt),
        .running(running), .irq(irq), .cache_base(cache_base),
        .cache_active(cache_active), .cache_flush(cache_flush),
        .cnt_wr_en(cnt_wr_en), .cnt_wr_data(cnt_wr_data), .flag_wr_en(flag_wr_en),
        .flag_sign(flag_sign), .flag_zero(flag_zero), .pc_jump(pc_jump),
        .pc_jump_addr(pc_jump_addr), .prefix_clear(prefix_clear)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] base_of(logic [23:0] p, logic [23:0] b);
        logic [23:0] d = p - b;
        return d[15:0] & 16'hFFF0;
    endfunction

    task automatic check_state();
        chk("R1 running", 32'(running), 32'(m_run));
        chk("R2/R3 irq", 32'(irq), 32'(m_irq));
        chk("R4/R6 cache_base", 32'(cache_base), 32'(m_base));
        chk("R4/R6 cache_active", 32'(cache_active), 32'(m_act));
        chk("R5 cache_flush", 32'(cache_flush), 32'(m_flush));
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; instr_valid = 1'b0; go_set = 1'b0; irq_ack = 1'b0;
        @(posedge clk); @(negedge clk);
        rst_n = 1'b1;
        m_run = 0; m_irq = 0; m_act = 0; m_flush = 0; m_base = '0;
        check_state(); // R10
    endtask

    task automatic step(logic v, logic [1:0] k, logic [23:0] p, logic [23:0] b,
                        logic [7:0] c, logic g, logic a, logic [15:0] n, logic [15:0] t);
        logic stp, cch, lp, ld;
        logic [15:0] dec, nb;
        @(negedge clk);
        instr_valid = v; op_kind = k; pc = p; bank_base = b; cfg_reg = c;
        go_set = g; irq_ack = a; loop_cnt = n; loop_tgt = t;
        #1;
        stp = v && k == 2'b01; cch = v && k == 2'b10; lp = v && k == 2'b11;
        dec = n - 16'd1;
        chk("R9 prefix_clear", 32'(prefix_clear), 32'(stp || cch || lp));
        chk("R7 cnt_wr_en", 32'(cnt_wr_en), 32'(lp));
        chk("R7 flag_wr_en", 32'(flag_wr_en), 32'(lp));
        chk("R8 pc_jump", 32'(pc_jump), 32'(lp && dec != 0));
        if (lp) begin
            chk("R7 cnt_wr_data", 32'(cnt_wr_data), 32'(dec));
            chk("R7 flag_sign", 32'(flag_sign), 32'(dec[15]));
            chk("R7 flag_zero", 32'(flag_zero), 32'(dec == 0));
            if (dec != 0) chk("R8 pc_jump_addr", 32'(pc_jump_addr), 32'(b + 24'(t)));
        end
        nb = base_of(p, b);
        ld = cch && !m_act && nb != m_base;
        @(posedge clk);
        m_run = stp ? 1'b0 : (g ? 1'b1 : m_run);
        m_irq = (stp && !c[7]) ? 1'b1 : (a ? 1'b0 : m_irq);
        if (ld) begin m_base = nb; m_act = 1'b1; end
        m_flush = ld;
        #1;
        check_state();
    endtask

    task automatic idle();
        step(1'b0, 2'b00, 24'h0, 24'h0, 8'h00, 1'b0, 1'b0, 16'h0, 16'h0);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            total++; fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        do_reset();
        // R6: base equal to the reset base (offset 7 aligns to 0) -> no load
        step(1, 2'b10, 24'h020007, 24'h020000, 8'h00, 0, 0, 0, 0);
        idle();
        // R1: start, then a masked halt (R2: no irq)
        step(0, 2'b00, 0, 0, 8'h00, 1, 0, 0, 0);
        step(1, 2'b01, 0, 0, 8'h80, 0, 0, 0, 0);
        // R1: halt and start together -> halt wins; R2 unmasked -> irq
        step(1, 2'b01, 0, 0, 8'h00, 1, 0, 0, 0);
        // R3: irq holds, ack clears, halt+ack keeps irq
        idle(); idle();
        step(0, 2'b00, 0, 0, 8'h00, 0, 1, 0, 0);
        step(1, 2'b01, 0, 0, 8'h00, 0, 1, 0, 0);
        // R4/R5: load base 0x1230, flush pulse then drop
        step(1, 2'b10, 24'h051234, 24'h040000, 8'h00, 0, 0, 0, 0);
        idle();
        // R6: already active -> ignored
        step(1, 2'b10, 24'h049990, 24'h040000, 8'h00, 0, 0, 0, 0);
        // R7/R8: counter 1 falls through; counter 0 wraps and jumps
        step(1, 2'b11, 0, 24'h100000, 8'h00, 0, 0, 16'h0001, 16'h0040);
        step(1, 2'b11, 0, 24'h100000, 8'h00, 0, 0, 16'h0000, 16'hFFF0);
        // R9: invalid strobe with a non-other class does nothing
        step(0, 2'b11, 0, 24'h100000, 8'h00, 0, 0, 16'h0005, 16'h0040);
        // Random rounds, each from reset so cache loads can recur.
        for (int r = 0; r < 30; r++) begin
            do_reset();
            for (int i = 0; i < 120; i++) begin
                logic [23:0] b = {$urandom()} & 24'hFF0000;
                logic [23:0] p = b + ({$urandom()} & 24'h00FFFF);
                logic [15:0] n = ($urandom_range(0, 3) == 0) ?
                                 16'($urandom_range(0, 2)) : 16'($urandom());
                step(1'($urandom_range(0, 3) != 0), 2'($urandom()), p, b,
                     8'($urandom()), 1'($urandom_range(0, 3) == 0),
                     1'($urandom_range(0, 3) == 0), n, 16'($urandom()));
            end
        end
        done = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule